// File: doc/BRIEF.md
# Uplink TPC Power Control Accumulator

This block sits in the uplink transmit chain of a handset modem. Once per slot it takes the transmit power control bit recovered from the downlink. From that bit it forms a signed per-slot command and keeps a saturating transmit power setting in whole dB. The demodulator upstream presents each bit on `slot_valid`/`tpc_bit`. The gain stage downstream reads `power` and the two limit flags.

The block runs one of two algorithms. In per-slot mode every bit moves the power by one step, and the step is 1 dB or 2 dB. In grouped mode the slots form consecutive sets of five, counted from frame start. A set moves the power by exactly 1 dB, and only on its fifth slot, and only when all five bits agree. A pulse on `frame_start` restarts set counting. On that pulse the block also adopts the algorithm on `alg_sel`, and the new algorithm already applies to a slot that arrives in the same cycle.

The slot input follows valid/ready rules, and `slot_ready` is held high at all times. The block never applies back-pressure, so a bit is consumed in every cycle where `slot_valid` is high, and the source never has to stall. The results appear one cycle after the slot is accepted. `cmd_valid` marks that cycle, and the result is not held or buffered afterwards.

Top module: `ul_tpc_accum`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `power` equals `pwr_init`, `cmd` is 0 and `cmd_valid` is 0. The stored algorithm is per-slot mode.
- R2: In per-slot mode (`alg_sel`=0) an accepted bit of 1 gives `cmd`=+1 (2'b01) and a bit of 0 gives `cmd`=-1 (2'b11). Both appear with `cmd_valid`=1 in the next cycle.
- R3: In per-slot mode `power` moves by `cmd` times 1 dB when `step_sel`=0, and by `cmd` times 2 dB when `step_sel`=1.
- R4: In grouped mode (`alg_sel`=1) the first four slots of a set give `cmd`=0, and `power` does not change on those slots.
- R5: In grouped mode the fifth slot of a set gives +1 if all five bits were 1 and -1 if all five were 0. Any other set gives 0.
- R6: In grouped mode the step is 1 dB whatever `step_sel` is.
- R7: A `frame_start` pulse, alone or together with a slot, discards a partly collected set. The next accepted slot (or the slot in the same cycle) becomes slot one of a new set.
- R8: A change of `alg_sel` has no effect until a `frame_start` pulse. The slot in the cycle of that pulse already uses the new algorithm.
- R9: `power` saturates at `pwr_max` and `pwr_min`. `at_max` or `at_min` is high while `power` equals that limit.
- R10: In a cycle without `slot_valid`, `power` keeps its value and the next cycle shows `cmd`=0 and `cmd_valid`=0, whatever `tpc_bit` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_init | input | PWR_W | Power loaded by reset, signed dB |
| pwr_min | input | PWR_W | Lower saturation limit, signed dB |
| pwr_max | input | PWR_W | Upper saturation limit, signed dB |
| alg_sel | input | 1 | 0 per-slot, 1 grouped; adopted at frame start |
| step_sel | input | 1 | Per-slot step: 0 for 1 dB, 1 for 2 dB |
| frame_start | input | 1 | Frame boundary pulse |
| slot_valid | input | 1 | A TPC bit is offered this cycle |
| slot_ready | output | 1 | Always 1; the slot is taken in every valid cycle |
| tpc_bit | input | 1 | Received TPC bit |
| cmd | output | 2 | Signed command of the last accepted slot |
| cmd_valid | output | 1 | High for one cycle after each accepted slot |
| power | output | PWR_W | Current power setting, signed dB |
| at_max | output | 1 | Power equals the upper limit |
| at_min | output | 1 | Power equals the lower limit |

## Verification
The per-slot algorithm is driven with alternating bits and with runs at both step sizes. Alternating bits show that each slot acts on its own, and long runs drive the power into both limits to show saturation and the flags. The grouped algorithm is driven with sets of all ones, sets of all zeros, and sets with a single odd bit in every position. These sets separate a unanimous decision from a majority decision and show that nothing moves before the fifth slot. A frame pulse arriving partway through a set, an algorithm change without a frame pulse, idle cycles with a toggling bit, and a long random stream complete the stimulus.

// File: rtl/ul_tpc_pkg.sv
package ul_tpc_pkg;
  typedef enum logic {
    ALG_PER_SLOT = 1'b0,
    ALG_GROUPED  = 1'b1
  } tpc_alg_e;

  typedef logic signed [1:0] tpc_cmd_t;

  localparam tpc_cmd_t CMD_HOLD = 2'sb00;
  localparam tpc_cmd_t CMD_UP   = 2'sb01;
  localparam tpc_cmd_t CMD_DOWN = 2'sb11;
endpackage

// File: rtl/tpc_group_collector.sv
module tpc_group_collector #(
  parameter int GROUP_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_fire,
  input  logic frame_start,
  input  logic tpc_bit,
  output logic grp_last,
  output logic grp_up,
  output logic grp_dn
);
  localparam int PW = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(GROUP_LEN - 1);

  logic [PW-1:0] pos_q, eff_pos;
  logic          ones_q, zeros_q, run_ones, run_zeros, first;

  always_comb begin
    eff_pos   = frame_start ? '0 : pos_q;
    first     = (eff_pos == '0);
    grp_last  = (eff_pos == LAST_POS);
    run_ones  = first ? tpc_bit  : (ones_q  & tpc_bit);
    run_zeros = first ? !tpc_bit : (zeros_q & !tpc_bit);
    grp_up    = slot_fire & grp_last & run_ones;
    grp_dn    = slot_fire & grp_last & run_zeros;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      ones_q  <= 1'b0;
      zeros_q <= 1'b0;
    end else if (slot_fire) begin
      pos_q   <= grp_last ? '0 : eff_pos + 1'b1;
      ones_q  <= run_ones;
      zeros_q <= run_zeros;
    end else if (frame_start) begin
      pos_q <= '0;
    end
  end

  // R7: a slot on a frame pulse is the first of a new set
  p_frame_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire && frame_start) |=> (pos_q == PW'(1)));

  p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);
endmodule

// File: rtl/tpc_cmd_former.sv
module tpc_cmd_former
  import ul_tpc_pkg::*;
#(
  parameter int STEP_SMALL = 1,
  parameter int STEP_LARGE = 2,
  parameter int SW = $clog2(STEP_LARGE + 1)
) (
  input  tpc_alg_e        mode,
  input  logic            tpc_bit,
  input  logic            step_sel,
  input  logic            grp_up,
  input  logic            grp_dn,
  output tpc_cmd_t        cmd,
  output logic [SW-1:0]   step
);
  always_comb begin
    if (mode == ALG_PER_SLOT) begin
      cmd  = tpc_bit ? CMD_UP : CMD_DOWN;
      step = step_sel ? SW'(STEP_LARGE) : SW'(STEP_SMALL);
    end else begin
      if (grp_up)      cmd = CMD_UP;
      else if (grp_dn) cmd = CMD_DOWN;
      else             cmd = CMD_HOLD;
      step = SW'(STEP_SMALL);
    end
  end
endmodule

// File: rtl/tpc_power_acc.sv
module tpc_power_acc
  import ul_tpc_pkg::*;
#(
  parameter int PWR_W = 8,
  parameter int SW = 2,
  parameter int STEP_LARGE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PWR_W-1:0] pwr_init,
  input  logic signed [PWR_W-1:0] pwr_min,
  input  logic signed [PWR_W-1:0] pwr_max,
  input  logic                    apply,
  input  logic                    grouped,
  input  tpc_cmd_t                cmd,
  input  logic [SW-1:0]           step,
  output logic signed [PWR_W-1:0] power,
  output logic                    at_max,
  output logic                    at_min
);
  localparam int EW = PWR_W + SW + 2;

  logic signed [PWR_W-1:0] power_q, next_pwr;
  logic signed [EW-1:0]    mag, delta, cur, sum, lo, hi;

  always_comb begin
    mag = $signed({{(EW-SW){1'b0}}, step});
    case (cmd)
      CMD_UP:   delta = mag;
      CMD_DOWN: delta = -mag;
      default:  delta = '0;
    endcase
    cur = EW'(power_q);
    lo  = EW'(pwr_min);
    hi  = EW'(pwr_max);
    sum = cur + delta;
    if (sum > hi)      next_pwr = pwr_max;
    else if (sum < lo) next_pwr = pwr_min;
    else               next_pwr = sum[PWR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     power_q <= pwr_init;
    else if (apply) power_q <= next_pwr;
  end

  assign power  = power_q;
  assign at_max = (power_q == pwr_max);
  assign at_min = (power_q == pwr_min);

  // R3: one slot never moves power by more than the large step
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> ((EW'(power_q) - EW'($past(power_q)) <= EW'(STEP_LARGE)) &&
               (EW'($past(power_q)) - EW'(power_q) <= EW'(STEP_LARGE))));
  // R6: grouped mode moves by at most one unit
  p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && grouped) |=> ((EW'(power_q) - EW'($past(power_q)) <= EW'(1)) &&
                            (EW'($past(power_q)) - EW'(power_q) <= EW'(1))));
  // R10: no slot, no power change
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(power_q));
endmodule

// File: rtl/ul_tpc_accum.sv
module ul_tpc_accum
  import ul_tpc_pkg::*;
#(
  parameter int PWR_W      = 8,
  parameter int GROUP_LEN  = 5,
  parameter int STEP_SMALL = 1,
  parameter int STEP_LARGE = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PWR_W-1:0] pwr_init,
  input  logic signed [PWR_W-1:0] pwr_min,
  input  logic signed [PWR_W-1:0] pwr_max,
  input  logic                    alg_sel,
  input  logic                    step_sel,
  input  logic                    frame_start,
  input  logic                    slot_valid,
  output logic                    slot_ready,
  input  logic                    tpc_bit,
  output logic [1:0]              cmd,
  output logic                    cmd_valid,
  output logic signed [PWR_W-1:0] power,
  output logic                    at_max,
  output logic                    at_min
);
  localparam int SW = $clog2(STEP_LARGE + 1);

  tpc_alg_e      alg_q, mode;
  tpc_cmd_t      slot_cmd, cmd_q;
  logic          cmd_v_q, slot_fire, grp_last, grp_up, grp_dn;
  logic [SW-1:0] step;

  assign slot_ready = 1'b1;
  assign slot_fire  = slot_valid & slot_ready;
  assign mode       = frame_start ? tpc_alg_e'(alg_sel) : alg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           alg_q <= ALG_PER_SLOT;
    else if (frame_start) alg_q <= tpc_alg_e'(alg_sel);
  end

  tpc_group_collector #(.GROUP_LEN(GROUP_LEN)) u_collect (
    .clk(clk), .rst_n(rst_n), .slot_fire(slot_fire), .frame_start(frame_start),
    .tpc_bit(tpc_bit), .grp_last(grp_last), .grp_up(grp_up), .grp_dn(grp_dn)
  );

  tpc_cmd_former #(.STEP_SMALL(STEP_SMALL), .STEP_LARGE(STEP_LARGE), .SW(SW)) u_form (
    .mode(mode), .tpc_bit(tpc_bit), .step_sel(step_sel), .grp_up(grp_up),
    .grp_dn(grp_dn), .cmd(slot_cmd), .step(step)
  );

  tpc_power_acc #(.PWR_W(PWR_W), .SW(SW), .STEP_LARGE(STEP_LARGE)) u_acc (
    .clk(clk), .rst_n(rst_n), .pwr_init(pwr_init), .pwr_min(pwr_min),
    .pwr_max(pwr_max), .apply(slot_fire), .grouped(mode == ALG_GROUPED),
    .cmd(slot_cmd), .step(step), .power(power), .at_max(at_max), .at_min(at_min)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_HOLD;
      cmd_v_q <= 1'b0;
    end else begin
      cmd_q   <= slot_fire ? slot_cmd : CMD_HOLD;
      cmd_v_q <= slot_fire;
    end
  end

  assign cmd       = cmd_q;
  assign cmd_valid = cmd_v_q;

  // R4: early slots of a set carry no command
  p_early_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire && mode == ALG_GROUPED && !grp_last) |=> (cmd_q == CMD_HOLD));
  // R10: idle cycle gives an empty result
  p_idle_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_fire |=> (!cmd_v_q && cmd_q == CMD_HOLD));
  // R2: per-slot mode never yields a zero command
  p_per_slot_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire && mode == ALG_PER_SLOT) |=> (cmd_v_q && cmd_q != CMD_HOLD));
endmodule

// File: tb/ul_tpc_accum_test.sv
module ul_tpc_accum_test;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [PW-1:0] pwr_init = 8'sd3, pwr_min = -8'sd10, pwr_max = 8'sd20;
  logic alg_sel = 1'b0, step_sel = 1'b0, frame_start = 1'b0;
  logic slot_valid = 1'b0, tpc_bit = 1'b0;
  logic slot_ready, cmd_valid, at_max, at_min;
  logic [1:0] cmd;
  logic signed [PW-1:0] power;

  int vectors = 0, errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  int m_pow, m_cmd, m_pos, m_alg;
  bit m_cv, m_ones, m_zeros;

  always #4 clk = ~clk;

  ul_tpc_accum uut (
    .clk(clk), .rst_n(rst_n), .pwr_init(pwr_init), .pwr_min(pwr_min),
    .pwr_max(pwr_max), .alg_sel(alg_sel), .step_sel(step_sel),
    .frame_start(frame_start), .slot_valid(slot_valid), .slot_ready(slot_ready),
    .tpc_bit(tpc_bit), .cmd(cmd), .cmd_valid(cmd_valid), .power(power),
    .at_max(at_max), .at_min(at_min)
  );

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    int alg, pos, c, st, nxt;
    if (!rst_n) begin
      m_pow = int'(pwr_init); m_cmd = 0; m_cv = 0; m_pos = 0; m_alg = 0;
      m_ones = 0; m_zeros = 0;
    end else begin
      alg = m_alg;
      if (frame_start) begin alg = int'(alg_sel); m_alg = alg; end
      if (slot_valid) begin
        pos = frame_start ? 0 : m_pos;
        if (pos == 0) begin m_ones = 1; m_zeros = 1; end
        m_ones  = m_ones & tpc_bit;
        m_zeros = m_zeros & !tpc_bit;
        if (alg == 0) begin
          c  = tpc_bit ? 1 : -1;
          st = step_sel ? 2 : 1;
        end else begin
          c  = (pos == 4) ? (m_ones ? 1 : (m_zeros ? -1 : 0)) : 0;
          st = 1;
        end
        m_pos = (pos == 4) ? 0 : pos + 1;
        nxt = m_pow + c * st;
        if (nxt > int'(pwr_max)) nxt = int'(pwr_max);
        if (nxt < int'(pwr_min)) nxt = int'(pwr_min);
        m_pow = nxt; m_cmd = c; m_cv = 1;
      end else begin
        if (frame_start) m_pos = 0;
        m_cmd = 0; m_cv = 0;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, act, exp);
    end
  endtask

  // compare away from the active edge, every cycle
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      check("power", int'(power), rst_n ? m_pow : int'(pwr_init));
      check("cmd", int'($signed(cmd)), rst_n ? m_cmd : 0);
      check("cmd_valid", int'(cmd_valid), rst_n ? int'(m_cv) : 0);
      check("at_max", int'(at_max), int'((rst_n ? m_pow : int'(pwr_init)) == int'(pwr_max)));
      check("at_min", int'(at_min), int'((rst_n ? m_pow : int'(pwr_init)) == int'(pwr_min)));
      check("slot_ready", int'(slot_ready), 1);
    end
  end

  task automatic slot(bit b, bit fs = 0);
    @(negedge clk);
    slot_valid = 1; tpc_bit = b; frame_start = fs;
    @(negedge clk);
    slot_valid = 0; frame_start = 0;
  endtask

  task automatic group5(bit [4:0] bits, bit fs_first);
    for (int i = 0; i < 5; i++) slot(bits[i], (i == 0) && fs_first);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;                       // R1: reset state compared by the monitor
    repeat (2) @(negedge clk);

    phase = "R2";
    for (int i = 0; i < 6; i++) slot(i[0]);
    phase = "R3";
    step_sel = 1;
    for (int i = 0; i < 4; i++) slot(i < 2);
    step_sel = 0;

    phase = "R8";                    // request grouped mode, no frame pulse yet
    alg_sel = 1;
    for (int i = 0; i < 3; i++) slot(1);
    phase = "R4";
    group5(5'b11111, 1);
    phase = "R5";
    group5(5'b00000, 0);
    group5(5'b11111, 0);
    for (int k = 0; k < 5; k++) group5(5'b11111 ^ (5'b1 << k), 0);
    for (int k = 0; k < 5; k++) group5(5'b1 << k, 0);
    phase = "R6";
    step_sel = 1;
    group5(5'b11111, 1);
    group5(5'b00000, 0);
    phase = "R7";
    slot(1, 1); slot(1); slot(0);
    group5(5'b11111, 1);             // restart mid-set
    slot(0); slot(0);
    @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
    group5(5'b00000, 0);

    phase = "R10";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tpc_bit = i[0]; frame_start = 0;
    end

    phase = "R9";
    alg_sel = 0; step_sel = 1;
    slot(1, 1);
    for (int i = 0; i < 14; i++) slot(1);
    for (int i = 0; i < 25; i++) slot(0);
    step_sel = 0;
    for (int i = 0; i < 3; i++) slot(0);

    phase = "R5";
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      slot_valid  = $urandom_range(0, 3) != 0;
      tpc_bit     = ($urandom_range(0, 9) < 8) ? tpc_bit : ~tpc_bit;
      frame_start = $urandom_range(0, 40) == 0;
      if ($urandom_range(0, 200) == 0) alg_sel = ~alg_sel;
      step_sel    = $urandom_range(0, 1);
    end
    @(negedge clk); slot_valid = 0; frame_start = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      done = 1;
      $display("FAIL watchdog %s: got 0 expected 1 completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule